// File: doc/BRIEF.md
# Modem Handshake Control with Diagnostic Loopback

This block keeps the five-bit modem control setting of a serial port and uses it to steer the handshake lines between the package pins and the serial core. Outside diagnostics it drives the active-low data-terminal-ready, request-to-send and general-purpose output 2 pins from the register. It passes the serial transmit and receive lines straight through. It inverts the active-low modem input pins (clear-to-send, data-set-ready, carrier-detect, ring) into active-high "asserted" levels for the modem status logic. One control bit also decides whether the interrupt pin is driven or left floating (output enable low).

When the loopback bit is set, the block cuts the serial lines and modem inputs off from the pins. The transmit pin rests at the idle level 1 and the core's transmit stream comes back as its receive stream. The four low control bits take the place of the modem inputs, and the three handshake output pins fall back to their inactive high level. Interrupts keep flowing, so the core's receive, transmit and modem-status logic can be tested with no external cable.

A register write takes effect on the rising clock edge where `wr_en` is high. The readback and all routed outputs follow the stored value with no further delay.

Top module: `modem_ctl_loop`

## Requirements
- R1: Control bit 0 (terminal ready) resets to 0. Outside loopback `pin_dtr_n` is the inverse of this bit: bit 0 = 1 drives the pin low.
- R2: Control bit 1 (request to send) resets to 0. Outside loopback `pin_rts_n` is the inverse of this bit.
- R3: Control bit 3 sets `pin_irq_oe`: 1 means the interrupt pin is driven, 0 means it floats. This holds in both modes. `pin_irq` equals `core_irq` while `pin_irq_oe` is 1 and 0 otherwise. Outside loopback `pin_op2_n` is the inverse of bit 3.
- R4: Outside loopback (bit 4 = 0), `pin_tx` follows `core_tx` and `core_rx` follows `pin_rx`. Each `eff_*` output is the inverse of its active-low pin.
- R5: In loopback (bit 4 = 1), `pin_tx` is held at 1 and `core_rx` follows `core_tx`. `pin_rx` has no effect.
- R6: In loopback the effective modem inputs come from the register: `eff_dsr` = bit 0, `eff_cts` = bit 1, `eff_ri` = bit 2, `eff_cd` = bit 3. The four modem input pins have no effect.
- R7: In loopback `pin_dtr_n`, `pin_rts_n` and `pin_op2_n` are all held at 1, whatever bits 0, 1 and 3 hold.
- R8: `rd_data` returns bits 4:0 as last written. Bits 7:5 always read 0, and a write with ones in 7:5 keeps none of them.
- R9: While `rst` is high at a clock edge the register clears to 0. Afterwards all three handshake pins are 1, `pin_irq_oe` is 0 and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write value |
| rd_data | output | 8 | Control register readback, bits 7:5 zero |
| core_tx | input | 1 | Serial stream from the transmitter |
| core_rx | output | 1 | Serial stream to the receiver |
| core_irq | input | 1 | Interrupt request from the core |
| eff_cts | output | 1 | Effective clear-to-send, 1 = asserted |
| eff_dsr | output | 1 | Effective data-set-ready, 1 = asserted |
| eff_cd | output | 1 | Effective carrier-detect, 1 = asserted |
| eff_ri | output | 1 | Effective ring indicator, 1 = asserted |
| pin_tx | output | 1 | Transmit pin |
| pin_rx | input | 1 | Receive pin |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_cd_n | input | 1 | Carrier-detect pin, active low |
| pin_ri_n | input | 1 | Ring pin, active low |
| pin_dtr_n | output | 1 | Terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| pin_op2_n | output | 1 | General output 2 pin, active low |
| pin_irq_oe | output | 1 | Interrupt pin output enable |
| pin_irq | output | 1 | Interrupt pin value |

## Verification
The assertions assume that `rst` is high at the first clock edges and that `wr_en` is never raised during reset. Several of them also read `rd_data[4]` as the mode in force for the current cycle. The stimulus writes only between resets. It changes every pin and core input at the falling edge, so the mode and each routed input stay steady for a whole cycle. Random pin levels are applied in both modes, which lets the bench confirm that in loopback the pins have no effect on any output.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;

    localparam int REG_W  = 8;
    localparam int CTRL_W = 5;
    localparam int MDM_N  = 4;

    // control bit positions
    localparam int B_DTR  = 0;
    localparam int B_RTS  = 1;
    localparam int B_AUX  = 2;
    localparam int B_OUT2 = 3;
    localparam int B_LOOP = 4;

    // modem input slots
    localparam int M_CTS = 0;
    localparam int M_DSR = 1;
    localparam int M_RI  = 2;
    localparam int M_CD  = 3;

    typedef struct packed {
        logic loop;
        logic out2;
        logic aux;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_t;

    // which control bit stands in for a modem input during loopback
    function automatic int loop_src(input int slot);
        case (slot)
            M_CTS:   return B_RTS;
            M_DSR:   return B_DTR;
            M_RI:    return B_AUX;
            default: return B_OUT2;
        endcase
    endfunction

endpackage

// File: rtl/mctl_reg.sv
module mctl_reg
    import modem_ctl_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int KEEP_W = CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mctl_t             ctrl,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - KEEP_W;

    logic [KEEP_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q <= wr_data[KEEP_W-1:0];
        end
    end

    assign ctrl    = mctl_t'(store_q);
    assign rd_data = {{PAD_W{1'b0}}, store_q};

endmodule

// File: rtl/mctl_route.sv
module mctl_route
    import modem_ctl_pkg::*;
(
    input  mctl_t            ctrl,
    input  logic             core_tx,
    input  logic             pin_rx,
    input  logic [MDM_N-1:0] pin_mdm_n,
    output logic             core_rx,
    output logic             pin_tx,
    output logic [MDM_N-1:0] eff_mdm
);
    logic [CTRL_W-1:0] ctrl_v;
    assign ctrl_v = ctrl;

    always_comb begin
        if (ctrl.loop) begin
            pin_tx  = 1'b1;
            core_rx = core_tx;
        end else begin
            pin_tx  = core_tx;
            core_rx = pin_rx;
        end
    end

    for (genvar i = 0; i < MDM_N; i++) begin : g_mdm
        localparam int SRC = loop_src(i);
        assign eff_mdm[i] = ctrl.loop ? ctrl_v[SRC] : ~pin_mdm_n[i];
    end

endmodule

// File: rtl/mctl_drive.sv
module mctl_drive
    import modem_ctl_pkg::*;
(
    input  mctl_t ctrl,
    input  logic  core_irq,
    output logic  pin_dtr_n,
    output logic  pin_rts_n,
    output logic  pin_op2_n,
    output logic  pin_irq_oe,
    output logic  pin_irq
);
    always_comb begin
        if (ctrl.loop) begin
            pin_dtr_n = 1'b1;
            pin_rts_n = 1'b1;
            pin_op2_n = 1'b1;
        end else begin
            pin_dtr_n = ~ctrl.dtr;
            pin_rts_n = ~ctrl.rts;
            pin_op2_n = ~ctrl.out2;
        end
        pin_irq_oe = ctrl.out2;
        pin_irq    = ctrl.out2 & core_irq;
    end

endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
    import modem_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             core_tx,
    output logic             core_rx,
    input  logic             core_irq,
    output logic             eff_cts,
    output logic             eff_dsr,
    output logic             eff_cd,
    output logic             eff_ri,
    output logic             pin_tx,
    input  logic             pin_rx,
    input  logic             pin_cts_n,
    input  logic             pin_dsr_n,
    input  logic             pin_cd_n,
    input  logic             pin_ri_n,
    output logic             pin_dtr_n,
    output logic             pin_rts_n,
    output logic             pin_op2_n,
    output logic             pin_irq_oe,
    output logic             pin_irq
);
    mctl_t ctrl;
    mdm_t  pins_n;
    mdm_t  eff;

    assign pins_n.cts = pin_cts_n;
    assign pins_n.dsr = pin_dsr_n;
    assign pins_n.cd  = pin_cd_n;
    assign pins_n.ri  = pin_ri_n;

    mctl_reg #(.DATA_W(REG_W), .KEEP_W(CTRL_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    mctl_route u_route (
        .ctrl      (ctrl),
        .core_tx   (core_tx),
        .pin_rx    (pin_rx),
        .pin_mdm_n (pins_n),
        .core_rx   (core_rx),
        .pin_tx    (pin_tx),
        .eff_mdm   (eff)
    );

    mctl_drive u_drive (
        .ctrl       (ctrl),
        .core_irq   (core_irq),
        .pin_dtr_n  (pin_dtr_n),
        .pin_rts_n  (pin_rts_n),
        .pin_op2_n  (pin_op2_n),
        .pin_irq_oe (pin_irq_oe),
        .pin_irq    (pin_irq)
    );

    assign eff_cts = eff.cts;
    assign eff_dsr = eff.dsr;
    assign eff_cd  = eff.cd;
    assign eff_ri  = eff.ri;

endmodule

// File: rtl/mctl_chk.sv
module mctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       core_tx,
    input logic       core_rx,
    input logic       core_irq,
    input logic       eff_cts,
    input logic       eff_dsr,
    input logic       eff_cd,
    input logic       eff_ri,
    input logic       pin_tx,
    input logic       pin_rx,
    input logic       pin_cts_n,
    input logic       pin_dsr_n,
    input logic       pin_cd_n,
    input logic       pin_ri_n,
    input logic       pin_dtr_n,
    input logic       pin_rts_n,
    input logic       pin_op2_n,
    input logic       pin_irq_oe,
    input logic       pin_irq
);
    p_dtr_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[4]) |=> (pin_dtr_n == !$past(wr_data[0])));

    p_rts_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[4]) |=> (pin_rts_n == !$past(wr_data[1])));

    p_irq_enable_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pin_irq_oe == $past(wr_data[3])));

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !pin_irq_oe |-> !pin_irq);

    p_normal_rx_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_data[4] |-> (core_rx == pin_rx && pin_tx == core_tx));

    p_loop_serial_r5: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (pin_tx && core_rx == core_tx));

    p_loop_modem_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (eff_dsr == rd_data[0] && eff_cts == rd_data[1] &&
                        eff_ri == rd_data[2] && eff_cd == rd_data[3]));

    p_loop_pins_r7: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (pin_dtr_n && pin_rts_n && pin_op2_n));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !pin_irq_oe));

endmodule

bind modem_ctl_loop mctl_chk u_chk (.*);

// File: tb/modem_ctl_loop_tb.sv
module modem_ctl_loop_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       core_tx = 1'b1;
    logic       core_irq = 1'b0;
    logic       pin_rx = 1'b1;
    logic       pin_cts_n = 1'b1;
    logic       pin_dsr_n = 1'b1;
    logic       pin_cd_n = 1'b1;
    logic       pin_ri_n = 1'b1;

    logic [7:0] rd_data;
    logic core_rx, eff_cts, eff_dsr, eff_cd, eff_ri, pin_tx;
    logic pin_dtr_n, pin_rts_n, pin_op2_n, pin_irq_oe, pin_irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int mreg = 0;   // reference model of the stored control value

    always #2 clk = ~clk;   // 250 MHz

    modem_ctl_loop u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .core_tx(core_tx), .core_rx(core_rx), .core_irq(core_irq),
        .eff_cts(eff_cts), .eff_dsr(eff_dsr), .eff_cd(eff_cd), .eff_ri(eff_ri),
        .pin_tx(pin_tx), .pin_rx(pin_rx), .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_cd_n(pin_cd_n), .pin_ri_n(pin_ri_n), .pin_dtr_n(pin_dtr_n),
        .pin_rts_n(pin_rts_n), .pin_op2_n(pin_op2_n), .pin_irq_oe(pin_irq_oe),
        .pin_irq(pin_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare every output with the behavioural model
    task automatic check_all();
        bit lp;
        lp = mreg[4];
        chk("R8", "rd_data", int'(rd_data), mreg & 'h1f);
        chk("R3", "pin_irq_oe", int'(pin_irq_oe), mreg[3]);
        chk("R3", "pin_irq", int'(pin_irq), mreg[3] ? int'(core_irq) : 0);
        if (!lp) begin
            chk("R1", "pin_dtr_n", int'(pin_dtr_n), mreg[0] ? 0 : 1);
            chk("R2", "pin_rts_n", int'(pin_rts_n), mreg[1] ? 0 : 1);
            chk("R3", "pin_op2_n", int'(pin_op2_n), mreg[3] ? 0 : 1);
            chk("R4", "pin_tx", int'(pin_tx), int'(core_tx));
            chk("R4", "core_rx", int'(core_rx), int'(pin_rx));
            chk("R4", "eff_cts", int'(eff_cts), pin_cts_n ? 0 : 1);
            chk("R4", "eff_dsr", int'(eff_dsr), pin_dsr_n ? 0 : 1);
            chk("R4", "eff_cd", int'(eff_cd), pin_cd_n ? 0 : 1);
            chk("R4", "eff_ri", int'(eff_ri), pin_ri_n ? 0 : 1);
        end else begin
            chk("R7", "pin_dtr_n", int'(pin_dtr_n), 1);
            chk("R7", "pin_rts_n", int'(pin_rts_n), 1);
            chk("R7", "pin_op2_n", int'(pin_op2_n), 1);
            chk("R5", "pin_tx", int'(pin_tx), 1);
            chk("R5", "core_rx", int'(core_rx), int'(core_tx));
            chk("R6", "eff_dsr", int'(eff_dsr), mreg[0]);
            chk("R6", "eff_cts", int'(eff_cts), mreg[1]);
            chk("R6", "eff_ri", int'(eff_ri), mreg[2]);
            chk("R6", "eff_cd", int'(eff_cd), mreg[3]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) mreg = 0;
        else if (wr_en) mreg = int'(wr_data) & 'h1f;
        @(negedge clk);
        check_all();
    endtask

    task automatic shake();
        core_tx   = 1'($urandom);
        core_irq  = 1'($urandom);
        pin_rx    = 1'($urandom);
        pin_cts_n = 1'($urandom);
        pin_dsr_n = 1'($urandom);
        pin_cd_n  = 1'($urandom);
        pin_ri_n  = 1'($urandom);
    endtask

    task automatic write_and_hold(input logic [7:0] v, input int hold);
        wr_en = 1'b1;
        wr_data = v;
        shake();
        step();
        wr_en = 1'b0;
        for (int k = 0; k < hold; k++) begin
            shake();
            step();
        end
    endtask

    initial begin
        step();
        step();
        // R9: reset state, all handshake pins inactive, interrupt pin floating
        chk("R9", "rd_data after reset", int'(rd_data), 0);
        chk("R9", "pin_dtr_n after reset", int'(pin_dtr_n), 1);
        chk("R9", "pin_rts_n after reset", int'(pin_rts_n), 1);
        chk("R9", "pin_op2_n after reset", int'(pin_op2_n), 1);
        chk("R9", "pin_irq_oe after reset", int'(pin_irq_oe), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin shake(); step(); end

        write_and_hold(8'h01, 6);   // R1
        write_and_hold(8'h02, 6);   // R2
        write_and_hold(8'h08, 8);   // R3
        write_and_hold(8'h0B, 6);
        write_and_hold(8'hE0, 4);   // R8 reserved bits dropped
        chk("R8", "reserved write readback", int'(rd_data), 0);
        write_and_hold(8'h10, 8);   // R5 R6 R7 loop with all zero
        write_and_hold(8'h1F, 8);   // loop with all ones
        write_and_hold(8'h15, 6);
        write_and_hold(8'h1A, 6);
        write_and_hold(8'hFF, 4);   // R8 upper bits dropped in loop
        chk("R8", "0xFF readback", int'(rd_data), 'h1f);
        write_and_hold(8'h0F, 6);   // back out of loop

        for (int n = 0; n < 300; n++) begin
            write_and_hold(8'($urandom), int'($urandom_range(0, 3)));
        end

        // R9: reset in the middle of operation
        wr_en = 1'b0;
        rst = 1'b1;
        step();
        chk("R9", "rd_data after late reset", int'(rd_data), 0);
        rst = 1'b0;
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule